// File: doc/BRIEF.md
# Dual-path I/O register space with single-bit operations

This block holds a small byte-wide register space of 64 locations. It answers three kinds of request. The I/O port path addresses locations 0x00 to 0x3F directly. The load/store path sees the same locations shifted up by 0x20, at data addresses 0x20 to 0x5F. The bit-operation path sets, clears or tests a single bit in the lower 32 locations. A test produces a skip condition whose polarity is picked per request.

Five locations are implemented and the rest read as zero:
- a plain control byte;
- a status byte whose flags are set by hardware events and cleared by writing one;
- a 6-bit storage address register;
- an 8-bit storage data register;
- a scratch byte above the bit-addressable range.

A single-bit set aimed at the status byte clears only the named flag. The other pending flags are not touched.

All results are registered. Read data, the skip condition, the illegal-access strobe and the load/store select appear in the cycle after the request.

Top module: `io_space`

## Requirements
- R1: After reset every location reads 0x00, and `rdata`, `ds_sel`, `skip` and `illegal` are low.
- R2: A port-path write (`io_en`=1, `io_we`=1) stores the byte at `io_addr`. A port-path read returns that location on `rdata` one cycle later. Stored widths: control at 0x05 keeps 8 bits, status at 0x0B keeps bits 3:0, storage address at 0x11 keeps bits 5:0, storage data at 0x12 keeps 8 bits, and scratch at 0x2A keeps 8 bits.
- R3: A load/store access with `ds_addr` in 0x20..0x5F reaches location `ds_addr`-0x20 with the same read and write behaviour as the port path. `ds_sel` is high in the following cycle.
- R4: A load/store access with `ds_addr` below 0x20 or above 0x5F writes nothing. It gives `rdata`=0 and `ds_sel`=0 in the following cycle.
- R5: Locations not listed in R2 read zero and ignore writes. Unimplemented bits read zero, including bits 7:6 of the storage address register.
- R6: A status flag is set by a one on `flag_evt` and cleared by writing a one to its bit. Writing zero leaves it unchanged. When an event and a clear hit the same bit in the same cycle, the event wins.
- R7: A bit set (`bop_op`=0) or bit clear (`bop_op`=1) on a plain register changes only bit `bop_bit` of location `bop_addr`.
- R8: A bit set on the status byte clears only that flag. A bit clear on the status byte changes nothing.
- R9: A bit test (`bop_op`=2) gives `skip`=1 in the next cycle when the addressed bit equals `bop_pol`, and 0 otherwise. `bop_op`=3 does nothing.
- R10: A bit operation with `bop_addr` of 0x20 or above changes nothing, gives `skip`=0, and pulses `illegal` high for one cycle.
- R11: When requests coincide, a port-path access takes precedence over a load/store access, which is then dropped. Any byte access suppresses a bit operation issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Port-path request |
| io_we | input | 1 | Port-path write (1) or read (0) |
| io_addr | input | 6 | Port-path location |
| io_wdata | input | 8 | Port-path write byte |
| ds_en | input | 1 | Load/store request |
| ds_we | input | 1 | Load/store write (1) or read (0) |
| ds_addr | input | 8 | Load/store data address |
| ds_wdata | input | 8 | Load/store write byte |
| bop_en | input | 1 | Bit-operation request |
| bop_op | input | 2 | 0 set, 1 clear, 2 test, 3 none |
| bop_addr | input | 6 | Bit-operation location |
| bop_bit | input | 3 | Bit index |
| bop_pol | input | 1 | Test polarity: skip when bit equals this |
| flag_evt | input | 4 | Hardware flag set pulses |
| rdata | output | 8 | Read byte, one cycle after a read |
| ds_sel | output | 1 | Load/store address was in range |
| skip | output | 1 | Bit-test skip condition |
| illegal | output | 1 | Bit operation out of range |

## Verification
The hardest case to reach is a bit set on the status byte while several other flags are pending. A read-modify-write bug only shows up there, and only if the neighbouring flags are still set. The bench first raises every flag with one event pulse. It then sweeps set and clear over every bit of every bit-addressable location in turn, reading the location back after each operation. As a result, each flag clear is observed while the not-yet-visited flags are still pending. The event-versus-clear collision and the coincident-request precedence are driven in dedicated cycles.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IO_AW  = 6;

    typedef enum logic [1:0] {
        BOP_SET = 2'd0,
        BOP_CLR = 2'd1,
        BOP_TST = 2'd2,
        BOP_NOP = 2'd3
    } bop_e;

    typedef struct packed {
        logic              vld;
        logic              we;
        logic [IO_AW-1:0]  addr;
        logic [BYTE_W-1:0] wdata;
    } acc_t;
endpackage

// File: rtl/io_space_decode.sv
module io_space_decode
    import io_space_pkg::*;
#(
    parameter int unsigned DS_AW   = 8,
    parameter int unsigned DS_BASE = 32
) (
    input  logic              io_en,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              ds_en,
    input  logic              ds_we,
    input  logic [DS_AW-1:0]  ds_addr,
    input  logic [BYTE_W-1:0] ds_wdata,
    output acc_t              acc,
    output logic              ds_hit
);
    localparam int unsigned SPAN = 1 << IO_AW;
    localparam logic [DS_AW:0] BASE_V = (DS_AW+1)'(DS_BASE);
    localparam logic [DS_AW:0] TOP_V  = (DS_AW+1)'(DS_BASE + SPAN);

    logic [DS_AW:0] ds_ext;
    logic [DS_AW:0] ds_off;

    assign ds_ext = {1'b0, ds_addr};
    assign ds_off = ds_ext - BASE_V;
    assign ds_hit = ds_en && (ds_ext >= BASE_V) && (ds_ext < TOP_V);

    always_comb begin
        acc = '0;
        if (io_en) begin
            acc.vld   = 1'b1;
            acc.we    = io_we;
            acc.addr  = io_addr;
            acc.wdata = io_wdata;
        end else if (ds_hit) begin
            acc.vld   = 1'b1;
            acc.we    = ds_we;
            acc.addr  = ds_off[IO_AW-1:0];
            acc.wdata = ds_wdata;
        end
    end
endmodule

// File: rtl/io_space_bitop.sv
module io_space_bitop
    import io_space_pkg::*;
#(
    parameter int unsigned BIT_LIMIT = 32
) (
    input  logic              bop_en,
    input  logic [1:0]        bop_op,
    input  logic [IO_AW-1:0]  bop_addr,
    input  logic [2:0]        bop_bit,
    input  logic              busy,
    output bop_e              op,
    output logic              go,
    output logic              illegal,
    output logic [BYTE_W-1:0] mask
);
    localparam logic [IO_AW:0] LIM_V = (IO_AW+1)'(BIT_LIMIT);

    logic in_range;

    assign op       = bop_e'(bop_op);
    assign in_range = {1'b0, bop_addr} < LIM_V;
    assign illegal  = bop_en && !in_range;
    assign go       = bop_en && in_range && !busy && (op != BOP_NOP);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign mask[i] = (bop_bit == 3'(i));
    end
endmodule

// File: rtl/io_space.sv
module io_space
    import io_space_pkg::*;
#(
    parameter int unsigned      FLAG_W    = 4,
    parameter int unsigned      EEA_W     = 6,
    parameter logic [IO_AW-1:0] CTRL_ADDR = 6'h05,
    parameter logic [IO_AW-1:0] FLAG_ADDR = 6'h0B,
    parameter logic [IO_AW-1:0] EEA_ADDR  = 6'h11,
    parameter logic [IO_AW-1:0] EED_ADDR  = 6'h12,
    parameter logic [IO_AW-1:0] HI_ADDR   = 6'h2A,
    parameter int unsigned      DS_AW     = 8,
    parameter int unsigned      DS_BASE   = 32,
    parameter int unsigned      BIT_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              ds_en,
    input  logic              ds_we,
    input  logic [DS_AW-1:0]  ds_addr,
    input  logic [BYTE_W-1:0] ds_wdata,
    input  logic              bop_en,
    input  logic [1:0]        bop_op,
    input  logic [IO_AW-1:0]  bop_addr,
    input  logic [2:0]        bop_bit,
    input  logic              bop_pol,
    input  logic [FLAG_W-1:0] flag_evt,
    output logic [BYTE_W-1:0] rdata,
    output logic              ds_sel,
    output logic              skip,
    output logic              illegal
);
    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [FLAG_W-1:0] flags;
        logic [EEA_W-1:0]  ee_addr;
        logic [BYTE_W-1:0] ee_data;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] rdata;
        logic              skip;
        logic              illegal;
        logic              ds_sel;
    } state_t;

    state_t st_d, st_q;

    acc_t              acc;
    logic              ds_hit;
    bop_e              op;
    logic              bop_go;
    logic              bop_bad;
    logic [BYTE_W-1:0] mask;

    io_space_decode #(
        .DS_AW   (DS_AW),
        .DS_BASE (DS_BASE)
    ) decode_i (
        .io_en    (io_en),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .ds_en    (ds_en),
        .ds_we    (ds_we),
        .ds_addr  (ds_addr),
        .ds_wdata (ds_wdata),
        .acc      (acc),
        .ds_hit   (ds_hit)
    );

    io_space_bitop #(
        .BIT_LIMIT (BIT_LIMIT)
    ) bitop_i (
        .bop_en   (bop_en),
        .bop_op   (bop_op),
        .bop_addr (bop_addr),
        .bop_bit  (bop_bit),
        .busy     (acc.vld),
        .op       (op),
        .go       (bop_go),
        .illegal  (bop_bad),
        .mask     (mask)
    );

    function automatic logic [BYTE_W-1:0] rd_byte(state_t s, logic [IO_AW-1:0] a);
        logic [BYTE_W-1:0] v;
        v = '0;
        case (a)
            CTRL_ADDR: v = s.ctrl;
            FLAG_ADDR: v = BYTE_W'(s.flags);
            EEA_ADDR:  v = BYTE_W'(s.ee_addr);
            EED_ADDR:  v = s.ee_data;
            HI_ADDR:   v = s.hi;
            default:   v = '0;
        endcase
        return v;
    endfunction

    logic [BYTE_W-1:0] cur;
    logic              wr_en;
    logic [IO_AW-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;

    always_comb begin
        cur     = rd_byte(st_q, bop_addr);
        wr_en   = 1'b0;
        wr_addr = acc.addr;
        wr_data = acc.wdata;
        if (acc.vld && acc.we) begin
            wr_en = 1'b1;
        end else if (bop_go && (op != BOP_TST)) begin
            wr_en   = 1'b1;
            wr_addr = bop_addr;
            if (bop_addr == FLAG_ADDR) begin
                // Flag byte: a set writes one only to the named bit.
                wr_data = (op == BOP_SET) ? mask : '0;
            end else begin
                wr_data = (op == BOP_SET) ? (cur | mask) : (cur & ~mask);
            end
        end

        st_d         = st_q;
        st_d.rdata   = (acc.vld && !acc.we) ? rd_byte(st_q, acc.addr) : '0;
        st_d.skip    = (bop_go && (op == BOP_TST)) ?
                       (((cur & mask) != '0) == bop_pol) : 1'b0;
        st_d.illegal = bop_bad;
        st_d.ds_sel  = ds_hit;

        if (wr_en) begin
            case (wr_addr)
                CTRL_ADDR: st_d.ctrl    = wr_data;
                FLAG_ADDR: st_d.flags   = st_q.flags & ~wr_data[FLAG_W-1:0];
                EEA_ADDR:  st_d.ee_addr = wr_data[EEA_W-1:0];
                EED_ADDR:  st_d.ee_data = wr_data;
                HI_ADDR:   st_d.hi      = wr_data;
                default:   ;
            endcase
        end
        st_d.flags = st_d.flags | flag_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign ds_sel  = st_q.ds_sel;
    assign skip    = st_q.skip;
    assign illegal = st_q.illegal;
endmodule

// File: rtl/io_space_chk.sv
module io_space_chk #(
    parameter int unsigned      FLAG_W    = 4,
    parameter int unsigned      EEA_W     = 6,
    parameter logic [5:0]       EEA_ADDR  = 6'h11,
    parameter int unsigned      DS_AW     = 8,
    parameter int unsigned      DS_BASE   = 32,
    parameter int unsigned      BIT_LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_en,
    input logic              io_we,
    input logic [5:0]        io_addr,
    input logic              ds_en,
    input logic              ds_we,
    input logic [DS_AW-1:0]  ds_addr,
    input logic              bop_en,
    input logic [1:0]        bop_op,
    input logic [5:0]        bop_addr,
    input logic [7:0]        rdata,
    input logic              ds_sel,
    input logic              skip,
    input logic              illegal,
    input logic [FLAG_W-1:0] flags_q,
    input logic [7:0]        hi_q
);
    localparam logic [6:0]     LIM_V  = 7'(BIT_LIMIT);
    localparam logic [DS_AW:0] BASE_V = (DS_AW+1)'(DS_BASE);
    localparam logic [DS_AW:0] TOP_V  = (DS_AW+1)'(DS_BASE + 64);

    logic ds_in;
    assign ds_in = ({1'b0, ds_addr} >= BASE_V) && ({1'b0, ds_addr} < TOP_V);

    assert_illegal_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(bop_en && ({1'b0, bop_addr} >= LIM_V)));

    assert_illegal_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !$past(io_en || ds_en)) |-> $stable(hi_q));

    assert_skip_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(bop_en && (bop_op == 2'd2) && ({1'b0, bop_addr} < LIM_V)));

    assert_ds_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ds_sel |-> $past(ds_en && ds_in));

    assert_ds_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ds_en && !ds_in && !io_en) |-> (!ds_sel && (rdata == 8'h00)));

    assert_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_q) & ~flags_q) != '0) |->
        $past((io_en && io_we) || (ds_en && ds_we) || bop_en));

    assert_eea_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_en && !io_we && (io_addr == EEA_ADDR)) |-> ((rdata >> EEA_W) == 8'h00));
endmodule

bind io_space io_space_chk #(
    .FLAG_W    (FLAG_W),
    .EEA_W     (EEA_W),
    .EEA_ADDR  (EEA_ADDR),
    .DS_AW     (DS_AW),
    .DS_BASE   (DS_BASE),
    .BIT_LIMIT (BIT_LIMIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_en    (io_en),
    .io_we    (io_we),
    .io_addr  (io_addr),
    .ds_en    (ds_en),
    .ds_we    (ds_we),
    .ds_addr  (ds_addr),
    .bop_en   (bop_en),
    .bop_op   (bop_op),
    .bop_addr (bop_addr),
    .rdata    (rdata),
    .ds_sel   (ds_sel),
    .skip     (skip),
    .illegal  (illegal),
    .flags_q  (st_q.flags),
    .hi_q     (st_q.hi)
);

// File: tb/io_space_tb_top.sv
module io_space_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       io_en, io_we;
    logic [5:0] io_addr;
    logic [7:0] io_wdata;
    logic       ds_en, ds_we;
    logic [7:0] ds_addr;
    logic [7:0] ds_wdata;
    logic       bop_en;
    logic [1:0] bop_op;
    logic [5:0] bop_addr;
    logic [2:0] bop_bit;
    logic       bop_pol;
    logic [3:0] flag_evt;
    logic [7:0] rdata;
    logic       ds_sel, skip, illegal;

    always #5 clk = ~clk;

    io_space dut_i (
        .clk(clk), .rst_n(rst_n),
        .io_en(io_en), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .bop_en(bop_en), .bop_op(bop_op), .bop_addr(bop_addr), .bop_bit(bop_bit),
        .bop_pol(bop_pol), .flag_evt(flag_evt),
        .rdata(rdata), .ds_sel(ds_sel), .skip(skip), .illegal(illegal)
    );

    localparam logic [5:0] A_CTRL = 6'h05, A_FLAG = 6'h0B, A_EEA = 6'h11,
                           A_EED = 6'h12, A_HI = 6'h2A;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] m [64];

    function automatic logic [7:0] keep_of(logic [5:0] a);
        case (a)
            A_CTRL, A_EED, A_HI: return 8'hFF;
            A_FLAG:              return 8'h0F;
            A_EEA:               return 8'h3F;
            default:             return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        io_en = 0; io_we = 0; io_addr = '0; io_wdata = '0;
        ds_en = 0; ds_we = 0; ds_addr = '0; ds_wdata = '0;
        bop_en = 0; bop_op = 2'd3; bop_addr = '0; bop_bit = '0; bop_pol = 0;
        flag_evt = '0;
    endtask

    task automatic m_wr(logic [5:0] a, logic [7:0] d);
        if (a == A_FLAG) m[a] = m[a] & ~d;
        else             m[a] = d & keep_of(a);
    endtask

    task automatic io_wr(logic [5:0] a, logic [7:0] d);
        io_en = 1; io_we = 1; io_addr = a; io_wdata = d;
        @(negedge clk); idle(); m_wr(a, d);
    endtask

    task automatic io_rd(logic [5:0] a, string tag);
        io_en = 1; io_we = 0; io_addr = a;
        @(negedge clk);
        chk(tag, rdata, m[a]);
        idle();
    endtask

    task automatic bop(logic [1:0] op, logic [5:0] a, logic [2:0] b, logic pol);
        bop_en = 1; bop_op = op; bop_addr = a; bop_bit = b; bop_pol = pol;
        @(negedge clk); idle();
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 64; i++) m[i] = 8'h00;

        // R1: reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 outs", {5'b0, ds_sel, skip, illegal}, 8'h00);
        for (int a = 0; a < 64; a++) io_rd(6'(a), "R1 reset read");

        // R2 / R5: port-path write and read of every location
        for (int a = 0; a < 64; a++) io_wr(6'(a), 8'((a * 37 + 91) & 255));
        for (int a = 0; a < 64; a++) io_rd(6'(a), "R2_R5 io read");

        // R3 / R4: load/store sweep over the whole data address range
        for (int d = 0; d < 256; d++) begin
            logic in_r;
            in_r = (d >= 32) && (d < 96);
            ds_en = 1; ds_we = 0; ds_addr = 8'(d);
            @(negedge clk);
            chk(in_r ? "R3 ds read" : "R4 ds miss read", rdata, in_r ? m[d - 32] : 8'h00);
            chk(in_r ? "R3 ds_sel" : "R4 ds_sel", {7'b0, ds_sel}, {7'b0, in_r});
            idle();
        end
        for (int d = 0; d < 256; d++) begin
            ds_en = 1; ds_we = 1; ds_addr = 8'(d); ds_wdata = 8'((d * 13 + 7) & 255);
            @(negedge clk); idle();
            if (d >= 32 && d < 96) m_wr(6'(d - 32), 8'((d * 13 + 7) & 255));
        end
        for (int a = 0; a < 64; a++) io_rd(6'(a), "R3_R4 after ds writes");
        io_rd(A_EEA, "R5 eea reserved bits");

        // R6: flag semantics
        flag_evt = 4'hF; @(negedge clk); idle(); m[A_FLAG] = m[A_FLAG] | 8'h0F;
        io_rd(A_FLAG, "R6 event set");
        io_wr(A_FLAG, 8'h05); io_rd(A_FLAG, "R6 w1c");
        io_wr(A_FLAG, 8'h00); io_rd(A_FLAG, "R6 write zero");
        io_en = 1; io_we = 1; io_addr = A_FLAG; io_wdata = 8'h0A; flag_evt = 4'h2;
        @(negedge clk); idle();
        m_wr(A_FLAG, 8'h0A); m[A_FLAG] = m[A_FLAG] | 8'h02;
        io_rd(A_FLAG, "R6 event beats clear");

        // R7 / R8 / R9: bit sweep over the bit-addressable range
        flag_evt = 4'hF; @(negedge clk); idle(); m[A_FLAG] = m[A_FLAG] | 8'h0F;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic bv;
                bv = m[a][b];
                bop(2'd2, 6'(a), 3'(b), 1'b1);
                chk("R9 test pol1", {7'b0, skip}, {7'b0, bv});
                bop(2'd2, 6'(a), 3'(b), 1'b0);
                chk("R9 test pol0", {7'b0, skip}, {7'b0, ~bv});
                bop(2'd0, 6'(a), 3'(b), 1'b0);
                if (a == A_FLAG) m[a] = m[a] & ~(8'h01 << b);
                else             m[a] = (m[a] | (8'h01 << b)) & keep_of(6'(a));
                io_rd(6'(a), (a == A_FLAG) ? "R8 bit set flag" : "R7 bit set");
                bop(2'd1, 6'(a), 3'(b), 1'b0);
                if (a != A_FLAG) m[a] = m[a] & ~(8'h01 << b);
                io_rd(6'(a), (a == A_FLAG) ? "R8 bit clear flag" : "R7 bit clear");
            end
        end
        io_wr(A_CTRL, 8'h3C);
        bop(2'd3, A_CTRL, 3'd2, 1'b1);
        chk("R9 nop skip", {7'b0, skip}, 8'h00);
        io_rd(A_CTRL, "R9 nop no change");

        // R10: out-of-range bit operations
        io_wr(A_HI, 8'h5A);
        for (int a = 32; a < 64; a++) begin
            bop(2'd0, 6'(a), 3'd0, 1'b0);
            chk("R10 illegal set", {6'b0, illegal, skip}, 8'h02);
            bop(2'd2, 6'(a), 3'd1, 1'b1);
            chk("R10 illegal test", {6'b0, illegal, skip}, 8'h02);
            io_rd(A_HI, "R10 hi unchanged");
        end
        bop(2'd2, A_CTRL, 3'd0, 1'b1);
        chk("R10 legal no strobe", {7'b0, illegal}, 8'h00);

        // R11: precedence of coincident requests
        io_en = 1; io_we = 1; io_addr = A_CTRL; io_wdata = 8'hA5;
        ds_en = 1; ds_we = 1; ds_addr = 8'h32; ds_wdata = 8'h77;
        bop_en = 1; bop_op = 2'd0; bop_addr = A_EEA; bop_bit = 3'd5;
        @(negedge clk); idle(); m_wr(A_CTRL, 8'hA5);
        io_rd(A_CTRL, "R11 io wins");
        io_rd(A_EED, "R11 ds dropped");
        io_rd(A_EEA, "R11 bitop dropped");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule